// File: doc/BRIEF.md
# Speculative Load Fill Buffer

This block sits between a load/store unit and a data cache and stops loads that are still speculative from changing what the cache holds. A speculative load that hits in the cache is answered straight from the cache. A speculative load that misses takes one of a small set of buffer entries and sends a memory request tagged with that entry's index. The returning line is kept in the entry rather than written into the cache, and the entry answers the load so that execution can go on.

When the load unit later retires the load by tag, the held line goes to the cache as a fill and the entry is released. When the load is thrown away by tag, the entry is released without any fill. If the load is still waiting for memory at that point, the response that arrives later is absorbed with no load response and no fill. Later speculative loads to a line that an entry already holds are answered from the entry without a memory request. Non-speculative loads skip the buffer and fill the cache directly. While a speculation fence is unresolved, speculative loads are held off at the request port.

Top module: `spec_fill_buf`

## Requirements
- R1: A load accepted while `cache_hit_i` is high gets `rsp_valid_o` on the next cycle with its own tag and the value of `cache_rdata_i`, and causes no memory request and no fill.
- R2: A speculative load that misses the cache and matches no held line issues one memory request on the next cycle, with the load's line address and an id below the entry count. The memory response for that id gives a load response on the next cycle with that load's tag and the returned data, and no cache fill.
- R3: A speculative cache miss to a line held by an entry that already has its data is answered on the next cycle with the held data and the new load's tag, and sends no memory request.
- R4: A commit for the tag of an entry holding data puts a fill with that entry's line address and data on `fill_valid_o` two cycles after the commit is sampled (if no other fill is ahead of it), and frees the entry, so a later miss to that line sends a new memory request.
- R5: A squash for the tag of an entry holding data frees it with no fill. A later commit of that tag has no effect, and a later miss to the line sends a new memory request.
- R6: A squash for the tag of an entry still waiting for memory makes the later response for its id produce no load response and no fill, and that response frees the entry.
- R7: While `fence_pending_i` is high, `ld_ready_o` is low for speculative loads. Non-speculative loads are not affected.
- R8: After reset `ld_ready_o` is high and all outputs marked valid are low. When all entries are in use, a speculative load that would need an entry sees `ld_ready_o` low, while cache hits are still accepted.
- R9: At most one fill is issued per cycle. When several committed entries wait, the entry with the older tag fills first. Tag a is older than tag b when bit TAG_W-1 of (a - b) mod 2^TAG_W is set. A fill for a non-speculative miss takes the fill port ahead of committed entries.
- R10: A non-speculative miss sends a memory request with id equal to the entry count. Its response produces a load response and a cache fill of the returned line on the same next cycle. Only one such miss is outstanding, and a second one sees `ld_ready_o` low.
- R11: `ld_ready_o` is low in any cycle where `mem_rsp_valid_i` is high.
- R12: A commit that arrives while the entry is still waiting for memory is remembered. The response then produces the load response on the next cycle and the fill on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | Load request valid |
| ld_ready_o | output | 1 | Load request accepted this cycle if valid |
| ld_tag_i | input | TAG_W | Load tag |
| ld_addr_i | input | ADDR_W | Line address of the load |
| ld_spec_i | input | 1 | Load is speculative |
| fence_pending_i | input | 1 | A speculation fence is unresolved |
| rsp_valid_o | output | 1 | Load data response valid |
| rsp_tag_o | output | TAG_W | Tag of the answered load |
| rsp_data_o | output | LINE_W | Line data for the load |
| cache_lookup_addr_o | output | ADDR_W | Address looked up in the cache |
| cache_hit_i | input | 1 | Lookup hit, same cycle |
| cache_rdata_i | input | LINE_W | Line data on a hit |
| fill_valid_o | output | 1 | Cache fill valid |
| fill_addr_o | output | ADDR_W | Fill line address |
| fill_data_o | output | LINE_W | Fill line data |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_id_o | output | MID_W | Request id (entry index, or entry count for non-speculative) |
| mem_req_addr_o | output | ADDR_W | Requested line address |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_id_i | input | MID_W | Id of the answered request |
| mem_rsp_data_i | input | LINE_W | Returned line |
| commit_valid_i | input | 1 | Load retire event |
| commit_tag_i | input | TAG_W | Tag of the retired load |
| squash_valid_i | input | 1 | Load squash event |
| squash_tag_i | input | TAG_W | Tag of the squashed load |

## Verification
The bench targets the cases where speculative state could leak into the cache. These are a squash before and after the data returns, where a faulty design would emit a stray fill or load response, and a commit before the data, where a faulty design would never fill. For fill ordering, the bench allocates the younger tag into the lower-numbered entry and also uses tags that straddle the wrap point. Stalling a non-speculative fill for one cycle lets two commits pile up, so an arbiter that picks by index or compares tags without wrap handling puts the fills in the wrong order. The bench also fills every entry, checks that the fence stalls speculative loads only, and checks that a line served from an entry sends no second memory request.

// File: rtl/spec_fill_pkg.sv
package spec_fill_pkg;
  typedef enum logic [2:0] {
    S_FREE,
    S_WAIT,
    S_READY,
    S_CMT,
    S_DROP
  } ent_st_e;
endpackage

// File: rtl/sfb_entry_table.sv
module sfb_entry_table
  import spec_fill_pkg::*;
#(
  parameter int N      = 8,
  parameter int TAG_W  = 6,
  parameter int ADDR_W = 26,
  parameter int LINE_W = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_en_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              mem_fill_en_i,
  input  logic [IDX_W-1:0]  mem_fill_idx_i,
  input  logic [LINE_W-1:0] mem_fill_data_i,
  input  logic              commit_valid_i,
  input  logic [TAG_W-1:0]  commit_tag_i,
  input  logic              squash_valid_i,
  input  logic [TAG_W-1:0]  squash_tag_i,
  input  logic              release_en_i,
  input  logic [IDX_W-1:0]  release_idx_i,
  output ent_st_e           st_o   [N],
  output logic [TAG_W-1:0]  tag_o  [N],
  output logic [ADDR_W-1:0] addr_o [N],
  output logic [LINE_W-1:0] data_o [N],
  output logic              fill_deliver_o
);

  for (genvar g = 0; g < N; g++) begin : g_ent
    ent_st_e           st_q;
    logic              ecmt_q;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LINE_W-1:0] data_q;
    logic sq_hit, cm_hit, al_hit, mf_hit, rl_hit;

    assign sq_hit = squash_valid_i && (tag_q == squash_tag_i);
    assign cm_hit = commit_valid_i && (tag_q == commit_tag_i);
    assign al_hit = alloc_en_i && (alloc_idx_i == IDX_W'(g));
    assign mf_hit = mem_fill_en_i && (mem_fill_idx_i == IDX_W'(g));
    assign rl_hit = release_en_i && (release_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q   <= S_FREE;
        ecmt_q <= 1'b0;
        tag_q  <= '0;
        addr_q <= '0;
        data_q <= '0;
      end else if (al_hit) begin
        st_q   <= S_WAIT;
        ecmt_q <= 1'b0;
        tag_q  <= alloc_tag_i;
        addr_q <= alloc_addr_i;
      end else begin
        unique case (st_q)
          S_WAIT: begin
            if (mf_hit) begin
              data_q <= mem_fill_data_i;
              if (sq_hit)                st_q <= S_FREE;
              else if (ecmt_q || cm_hit) st_q <= S_CMT;
              else                       st_q <= S_READY;
            end else if (sq_hit) begin
              st_q <= S_DROP;
            end else if (cm_hit) begin
              ecmt_q <= 1'b1;  // retired before data arrived
            end
          end
          S_DROP:  if (mf_hit) st_q <= S_FREE;
          S_READY: begin
            if (sq_hit)      st_q <= S_FREE;
            else if (cm_hit) st_q <= S_CMT;
          end
          S_CMT:   if (rl_hit) st_q <= S_FREE;
          default: ;
        endcase
      end
    end

    assign st_o[g]   = st_q;
    assign tag_o[g]  = tag_q;
    assign addr_o[g] = addr_q;
    assign data_o[g] = data_q;
  end

  assign fill_deliver_o = mem_fill_en_i && (st_o[mem_fill_idx_i] == S_WAIT)
                          && !(squash_valid_i && (tag_o[mem_fill_idx_i] == squash_tag_i));

  // R8
  alloc_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en_i |-> st_o[alloc_idx_i] == S_FREE);

  // R9
  release_cmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_en_i |-> st_o[release_idx_i] == S_CMT);

  // R6
  drop_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_fill_en_i && st_o[mem_fill_idx_i] == S_DROP) |=> st_o[$past(mem_fill_idx_i)] == S_FREE);

endmodule

// File: rtl/sfb_lookup.sv
module sfb_lookup
  import spec_fill_pkg::*;
#(
  parameter int N      = 8,
  parameter int ADDR_W = 26,
  localparam int IDX_W = $clog2(N)
) (
  input  ent_st_e           st_i   [N],
  input  logic [ADDR_W-1:0] addr_i [N],
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              free_found_o,
  output logic [IDX_W-1:0]  free_idx_o,
  output logic              hit_found_o,
  output logic [IDX_W-1:0]  hit_idx_o
);

  logic [N-1:0] free_vec, hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_match
    assign free_vec[g] = (st_i[g] == S_FREE);
    assign hit_vec[g]  = ((st_i[g] == S_READY) || (st_i[g] == S_CMT))
                         && (addr_i[g] == req_addr_i);
  end

  always_comb begin
    free_idx_o = '0;
    hit_idx_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) free_idx_o = IDX_W'(i);
      if (hit_vec[i])  hit_idx_o  = IDX_W'(i);
    end
  end

  assign free_found_o = |free_vec;
  assign hit_found_o  = |hit_vec;

endmodule

// File: rtl/sfb_commit_arb.sv
module sfb_commit_arb
  import spec_fill_pkg::*;
#(
  parameter int N      = 8,
  parameter int TAG_W  = 6,
  localparam int IDX_W = $clog2(N)
) (
  input  ent_st_e          st_i  [N],
  input  logic [TAG_W-1:0] tag_i [N],
  output logic             sel_valid_o,
  output logic [IDX_W-1:0] sel_idx_o
);

  // wrap-aware: a is older when (a - b) is negative in TAG_W bits
  function automatic logic older(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
    logic [TAG_W-1:0] d;
    d = a - b;
    return d[TAG_W-1];
  endfunction

  logic [TAG_W-1:0] best_tag;

  always_comb begin
    sel_valid_o = 1'b0;
    sel_idx_o   = '0;
    best_tag    = '0;
    for (int i = 0; i < N; i++) begin
      if ((st_i[i] == S_CMT) && (!sel_valid_o || older(tag_i[i], best_tag))) begin
        sel_valid_o = 1'b1;
        sel_idx_o   = IDX_W'(i);
        best_tag    = tag_i[i];
      end
    end
  end

endmodule

// File: rtl/spec_fill_buf.sv
module spec_fill_buf
  import spec_fill_pkg::*;
#(
  parameter int N      = 8,
  parameter int TAG_W  = 6,
  parameter int ADDR_W = 26,
  parameter int LINE_W = 64,
  localparam int IDX_W = $clog2(N),
  localparam int MID_W = $clog2(N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  output logic              ld_ready_o,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              ld_spec_i,
  input  logic              fence_pending_i,
  output logic              rsp_valid_o,
  output logic [TAG_W-1:0]  rsp_tag_o,
  output logic [LINE_W-1:0] rsp_data_o,
  output logic [ADDR_W-1:0] cache_lookup_addr_o,
  input  logic              cache_hit_i,
  input  logic [LINE_W-1:0] cache_rdata_i,
  output logic              fill_valid_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  output logic [LINE_W-1:0] fill_data_o,
  output logic              mem_req_valid_o,
  output logic [MID_W-1:0]  mem_req_id_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [MID_W-1:0]  mem_rsp_id_i,
  input  logic [LINE_W-1:0] mem_rsp_data_i,
  input  logic              commit_valid_i,
  input  logic [TAG_W-1:0]  commit_tag_i,
  input  logic              squash_valid_i,
  input  logic [TAG_W-1:0]  squash_tag_i
);

  localparam logic [MID_W-1:0] NS_ID = MID_W'(N);

  ent_st_e           ent_st   [N];
  logic [TAG_W-1:0]  ent_tag  [N];
  logic [ADDR_W-1:0] ent_addr [N];
  logic [LINE_W-1:0] ent_data [N];

  logic              free_found, buf_hit;
  logic [IDX_W-1:0]  free_idx, hit_idx, arb_idx;
  logic              arb_valid, ent_deliver;
  logic              need_entry, ns_miss, buf_serve, accept;
  logic              rsp_is_ns, rsp_is_ent, alloc_en, release_en;
  logic [IDX_W-1:0]  mem_fill_idx;

  logic              ns_busy_q;
  logic [TAG_W-1:0]  ns_tag_q;
  logic [ADDR_W-1:0] ns_addr_q;

  assign cache_lookup_addr_o = ld_addr_i;

  assign need_entry = ld_spec_i && !cache_hit_i && !buf_hit;
  assign buf_serve  = ld_spec_i && !cache_hit_i && buf_hit;
  assign ns_miss    = !ld_spec_i && !cache_hit_i;

  assign ld_ready_o = !mem_rsp_valid_i
                      && !(ld_spec_i && fence_pending_i)
                      && !(need_entry && !free_found)
                      && !(ns_miss && ns_busy_q);
  assign accept     = ld_valid_i && ld_ready_o;

  assign rsp_is_ns    = mem_rsp_valid_i && (mem_rsp_id_i == NS_ID);
  assign rsp_is_ent   = mem_rsp_valid_i && (mem_rsp_id_i < NS_ID);
  assign mem_fill_idx = mem_rsp_id_i[IDX_W-1:0];
  assign alloc_en     = accept && need_entry;
  assign release_en   = arb_valid && !rsp_is_ns;  // bypass fill has the port

  sfb_entry_table #(
    .N(N), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .LINE_W(LINE_W)
  ) u_table (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .alloc_en_i      (alloc_en),
    .alloc_idx_i     (free_idx),
    .alloc_tag_i     (ld_tag_i),
    .alloc_addr_i    (ld_addr_i),
    .mem_fill_en_i   (rsp_is_ent),
    .mem_fill_idx_i  (mem_fill_idx),
    .mem_fill_data_i (mem_rsp_data_i),
    .commit_valid_i  (commit_valid_i),
    .commit_tag_i    (commit_tag_i),
    .squash_valid_i  (squash_valid_i),
    .squash_tag_i    (squash_tag_i),
    .release_en_i    (release_en),
    .release_idx_i   (arb_idx),
    .st_o            (ent_st),
    .tag_o           (ent_tag),
    .addr_o          (ent_addr),
    .data_o          (ent_data),
    .fill_deliver_o  (ent_deliver)
  );

  sfb_lookup #(.N(N), .ADDR_W(ADDR_W)) u_lookup (
    .st_i         (ent_st),
    .addr_i       (ent_addr),
    .req_addr_i   (ld_addr_i),
    .free_found_o (free_found),
    .free_idx_o   (free_idx),
    .hit_found_o  (buf_hit),
    .hit_idx_o    (hit_idx)
  );

  sfb_commit_arb #(.N(N), .TAG_W(TAG_W)) u_arb (
    .st_i        (ent_st),
    .tag_i       (ent_tag),
    .sel_valid_o (arb_valid),
    .sel_idx_o   (arb_idx)
  );

  // load response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_tag_o   <= '0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (rsp_is_ns) begin
        rsp_valid_o <= 1'b1;
        rsp_tag_o   <= ns_tag_q;
        rsp_data_o  <= mem_rsp_data_i;
      end else if (ent_deliver) begin
        rsp_valid_o <= 1'b1;
        rsp_tag_o   <= ent_tag[mem_fill_idx];
        rsp_data_o  <= mem_rsp_data_i;
      end else if (accept && cache_hit_i) begin
        rsp_valid_o <= 1'b1;
        rsp_tag_o   <= ld_tag_i;
        rsp_data_o  <= cache_rdata_i;
      end else if (accept && buf_serve) begin
        rsp_valid_o <= 1'b1;
        rsp_tag_o   <= ld_tag_i;
        rsp_data_o  <= ent_data[hit_idx];
      end
    end
  end

  // memory request and bypass tracking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_req_valid_o <= 1'b0;
      mem_req_id_o    <= '0;
      mem_req_addr_o  <= '0;
      ns_busy_q       <= 1'b0;
      ns_tag_q        <= '0;
      ns_addr_q       <= '0;
    end else begin
      mem_req_valid_o <= alloc_en || (accept && ns_miss);
      if (alloc_en) begin
        mem_req_id_o   <= MID_W'(free_idx);
        mem_req_addr_o <= ld_addr_i;
      end else if (accept && ns_miss) begin
        mem_req_id_o   <= NS_ID;
        mem_req_addr_o <= ld_addr_i;
        ns_busy_q      <= 1'b1;
        ns_tag_q       <= ld_tag_i;
        ns_addr_q      <= ld_addr_i;
      end
      if (rsp_is_ns) ns_busy_q <= 1'b0;
    end
  end

  // cache fill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_valid_o <= 1'b0;
      fill_addr_o  <= '0;
      fill_data_o  <= '0;
    end else begin
      fill_valid_o <= 1'b0;
      if (rsp_is_ns) begin
        fill_valid_o <= 1'b1;
        fill_addr_o  <= ns_addr_q;
        fill_data_o  <= mem_rsp_data_i;
      end else if (release_en) begin
        fill_valid_o <= 1'b1;
        fill_addr_o  <= ent_addr[arb_idx];
        fill_data_o  <= ent_data[arb_idx];
      end
    end
  end

  // R1
  hit_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cache_hit_i) |=> rsp_valid_o && rsp_tag_o == $past(ld_tag_i)
                                && rsp_data_o == $past(cache_rdata_i));

  // R3
  buf_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && buf_serve) |=> !mem_req_valid_o);

endmodule

// File: tb/spec_fill_buf_test.sv
module spec_fill_buf_test;
  localparam int N = 8, TAG_W = 6, ADDR_W = 26, LINE_W = 64, MID_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              ld_valid = 0, ld_spec = 0, fence = 0, cache_hit = 0;
  logic [TAG_W-1:0]  ld_tag = 0, commit_tag = 0, squash_tag = 0;
  logic [ADDR_W-1:0] ld_addr = 0;
  logic [LINE_W-1:0] cache_rdata = 0, mem_data = 0;
  logic              mem_rsp_valid = 0, commit_valid = 0, squash_valid = 0;
  logic [MID_W-1:0]  mem_rsp_id = 0;
  logic              ld_ready, rsp_valid, fill_valid, mreq_valid;
  logic [TAG_W-1:0]  rsp_tag;
  logic [LINE_W-1:0] rsp_data, fill_data;
  logic [ADDR_W-1:0] lookup_addr, fill_addr, mreq_addr;
  logic [MID_W-1:0]  mreq_id;

  spec_fill_buf uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_valid_i(ld_valid), .ld_ready_o(ld_ready), .ld_tag_i(ld_tag), .ld_addr_i(ld_addr),
    .ld_spec_i(ld_spec), .fence_pending_i(fence),
    .rsp_valid_o(rsp_valid), .rsp_tag_o(rsp_tag), .rsp_data_o(rsp_data),
    .cache_lookup_addr_o(lookup_addr), .cache_hit_i(cache_hit), .cache_rdata_i(cache_rdata),
    .fill_valid_o(fill_valid), .fill_addr_o(fill_addr), .fill_data_o(fill_data),
    .mem_req_valid_o(mreq_valid), .mem_req_id_o(mreq_id), .mem_req_addr_o(mreq_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_id_i(mem_rsp_id), .mem_rsp_data_i(mem_data),
    .commit_valid_i(commit_valid), .commit_tag_i(commit_tag),
    .squash_valid_i(squash_valid), .squash_tag_i(squash_tag)
  );

  int n_tests = 0, n_fail = 0, mreq_cnt = 0;
  string cur_req = "R8";
  logic [TAG_W-1:0]  er_tag[$];
  logic [LINE_W-1:0] er_data[$], ef_data[$];
  logic [ADDR_W-1:0] ef_addr[$], mq_addr[$];
  logic [MID_W-1:0]  mq_id[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // monitor: scoreboard for responses and fills, capture of memory requests
  always @(negedge clk) if (rst_n) begin
    if (rsp_valid) begin
      if (er_tag.size() == 0) check(0, cur_req, "unexpected load response tag", 64'(rsp_tag), 0);
      else begin
        logic [TAG_W-1:0] t; logic [LINE_W-1:0] d;
        t = er_tag.pop_front(); d = er_data.pop_front();
        check(rsp_tag == t && rsp_data == d, cur_req, "response tag/data",
              {rsp_tag, rsp_data[31:0]}, {t, d[31:0]});
      end
    end
    if (fill_valid) begin
      if (ef_addr.size() == 0) check(0, cur_req, "unexpected fill addr", 64'(fill_addr), 0);
      else begin
        logic [ADDR_W-1:0] a; logic [LINE_W-1:0] d;
        a = ef_addr.pop_front(); d = ef_data.pop_front();
        check(fill_addr == a && fill_data == d, cur_req, "fill addr/data",
              {fill_addr, fill_data[31:0]}, {a, d[31:0]});
      end
    end
    if (mreq_valid) begin
      mq_id.push_back(mreq_id); mq_addr.push_back(mreq_addr); mreq_cnt++;
    end
  end

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
    #1;
  endtask

  task automatic exp_rsp(input logic [TAG_W-1:0] t, input logic [LINE_W-1:0] d);
    er_tag.push_back(t); er_data.push_back(d);
  endtask

  task automatic exp_fill(input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] d);
    ef_addr.push_back(a); ef_data.push_back(d);
  endtask

  task automatic issue(input logic [TAG_W-1:0] t, input logic [ADDR_W-1:0] a, input bit spec,
                       input bit hit, input logic [LINE_W-1:0] hd, input bit exp_rdy, input string req);
    @(negedge clk);
    ld_valid = 1; ld_tag = t; ld_addr = a; ld_spec = spec; cache_hit = hit; cache_rdata = hd;
    #1 check(ld_ready == exp_rdy, req, "ld_ready", 64'(ld_ready), 64'(exp_rdy));
    @(negedge clk);
    ld_valid = 0; cache_hit = 0;
  endtask

  task automatic mem_resp(input logic [MID_W-1:0] id, input logic [LINE_W-1:0] d);
    @(negedge clk); mem_rsp_valid = 1; mem_rsp_id = id; mem_data = d;
    @(negedge clk); mem_rsp_valid = 0;
  endtask

  task automatic commit(input logic [TAG_W-1:0] t);
    @(negedge clk); commit_valid = 1; commit_tag = t;
    @(negedge clk); commit_valid = 0;
  endtask

  task automatic squash(input logic [TAG_W-1:0] t);
    @(negedge clk); squash_valid = 1; squash_tag = t;
    @(negedge clk); squash_valid = 0;
  endtask

  task automatic pop_req(input string req, input logic [ADDR_W-1:0] a, output logic [MID_W-1:0] id);
    id = 0;
    if (mq_id.size() == 0) check(0, req, "missing memory request", 0, 1);
    else begin
      logic [ADDR_W-1:0] ra;
      id = mq_id.pop_front(); ra = mq_addr.pop_front();
      check(ra == a, req, "memory request address", 64'(ra), 64'(a));
    end
  endtask

  task automatic drain(input string req);
    idle(4);
    check(er_tag.size() == 0, req, "responses still expected", 64'(er_tag.size()), 0);
    check(ef_addr.size() == 0, req, "fills still expected", 64'(ef_addr.size()), 0);
  endtask

  // older tag is tb; ta is allocated first so it sits in the lower entry
  task automatic order_test(input logic [TAG_W-1:0] ta, input logic [TAG_W-1:0] tb,
                            input logic [ADDR_W-1:0] base, input string req);
    logic [MID_W-1:0] ia, ib, in_;
    issue(ta, base, 1, 0, 0, 1, req);
    issue(tb, base + 1, 1, 0, 0, 1, req);
    issue(6'd50, base + 2, 0, 0, 0, 1, req);
    idle(1);
    pop_req(req, base, ia); pop_req(req, base + 1, ib); pop_req(req, base + 2, in_);
    check(in_ == MID_W'(N), req, "bypass id", 64'(in_), N);
    exp_rsp(ta, 64'hA0 + 64'(ta)); mem_resp(ia, 64'hA0 + 64'(ta));
    exp_rsp(tb, 64'hB0 + 64'(tb)); mem_resp(ib, 64'hB0 + 64'(tb));
    exp_rsp(6'd50, 64'hC0);
    exp_fill(base + 2, 64'hC0);
    exp_fill(base + 1, 64'hB0 + 64'(tb));
    exp_fill(base, 64'hA0 + 64'(ta));
    @(negedge clk); commit_valid = 1; commit_tag = ta;
    @(negedge clk); commit_tag = tb; mem_rsp_valid = 1; mem_rsp_id = in_; mem_data = 64'hC0;
    @(negedge clk); commit_valid = 0; mem_rsp_valid = 0;
    drain(req);
  endtask

  initial begin
    #2_000_000;
    check(0, cur_req, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    logic [MID_W-1:0] id, ids[8];
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R8 reset state
    check(ld_ready && !rsp_valid && !fill_valid && !mreq_valid, "R8", "reset outputs",
          {ld_ready, rsp_valid, fill_valid, mreq_valid}, 4'b1000);

    cur_req = "R1";
    c0 = mreq_cnt;
    exp_rsp(1, 64'hAAAA_0001);
    issue(1, 26'h100, 1, 1, 64'hAAAA_0001, 1, "R1");
    idle(2);
    check(mreq_cnt == c0, "R1", "memory requests on hit", mreq_cnt - c0, 0);

    cur_req = "R2";
    issue(2, 26'h200, 1, 0, 0, 1, "R2");
    idle(1);
    pop_req("R2", 26'h200, id);
    check(id < MID_W'(N), "R2", "entry id", 64'(id), N - 1);
    exp_rsp(2, 64'hD2);
    mem_resp(id, 64'hD2);
    drain("R2");

    cur_req = "R3";
    c0 = mreq_cnt;
    exp_rsp(3, 64'hD2);
    issue(3, 26'h200, 1, 0, 0, 1, "R3");
    idle(2);
    check(mreq_cnt == c0, "R3", "memory requests on buffer hit", mreq_cnt - c0, 0);

    cur_req = "R4";
    exp_fill(26'h200, 64'hD2);
    commit(2);
    drain("R4");
    c0 = mreq_cnt;
    issue(4, 26'h200, 1, 0, 0, 1, "R4");
    idle(1);
    check(mreq_cnt == c0 + 1, "R4", "new request after release", mreq_cnt - c0, 1);
    pop_req("R4", 26'h200, id);

    cur_req = "R6";
    squash(4);
    mem_resp(id, 64'hDEAD);
    drain("R6");

    cur_req = "R5";
    issue(5, 26'h300, 1, 0, 0, 1, "R5");
    idle(1);
    pop_req("R5", 26'h300, id);
    exp_rsp(5, 64'hD5);
    mem_resp(id, 64'hD5);
    squash(5);
    commit(5);
    drain("R5");
    c0 = mreq_cnt;
    issue(6, 26'h300, 1, 0, 0, 1, "R5");
    idle(1);
    check(mreq_cnt == c0 + 1, "R5", "squashed line not served", mreq_cnt - c0, 1);
    pop_req("R5", 26'h300, id);
    exp_rsp(6, 64'hD6);
    mem_resp(id, 64'hD6);
    squash(6);
    drain("R5");

    cur_req = "R12";
    issue(7, 26'h400, 1, 0, 0, 1, "R12");
    idle(1);
    pop_req("R12", 26'h400, id);
    commit(7);
    exp_rsp(7, 64'hD7);
    exp_fill(26'h400, 64'hD7);
    mem_resp(id, 64'hD7);
    drain("R12");

    cur_req = "R7";
    fence = 1;
    issue(8, 26'h500, 1, 1, 64'hE8, 0, "R7");
    exp_rsp(9, 64'hE9);
    issue(9, 26'h500, 0, 1, 64'hE9, 1, "R7");
    fence = 0;
    drain("R7");

    cur_req = "R10";
    issue(10, 26'h600, 0, 0, 0, 1, "R10");
    idle(1);
    pop_req("R10", 26'h600, id);
    check(id == MID_W'(N), "R10", "bypass id", 64'(id), N);
    issue(11, 26'h700, 0, 0, 0, 0, "R10");
    exp_rsp(10, 64'hDA);
    exp_fill(26'h600, 64'hDA);
    mem_resp(id, 64'hDA);
    drain("R10");

    cur_req = "R11";
    issue(12, 26'h800, 1, 0, 0, 1, "R11");
    idle(1);
    pop_req("R11", 26'h800, id);
    exp_rsp(12, 64'hDC);
    @(negedge clk);
    mem_rsp_valid = 1; mem_rsp_id = id; mem_data = 64'hDC;
    ld_valid = 1; ld_tag = 13; ld_addr = 26'h900; ld_spec = 1; cache_hit = 1;
    #1 check(!ld_ready, "R11", "ld_ready during memory response", 64'(ld_ready), 0);
    @(negedge clk);
    mem_rsp_valid = 0; ld_valid = 0; cache_hit = 0;
    squash(12);
    drain("R11");

    cur_req = "R8";
    for (int i = 0; i < N; i++) issue(6'(20 + i), 26'h1000 + 26'(i), 1, 0, 0, 1, "R8");
    idle(1);
    for (int i = 0; i < N; i++) pop_req("R8", 26'h1000 + 26'(i), ids[i]);
    issue(28, 26'h2000, 1, 0, 0, 0, "R8");
    exp_rsp(29, 64'hF9);
    issue(29, 26'h2001, 1, 1, 64'hF9, 1, "R8");
    for (int i = 0; i < N; i++) squash(6'(20 + i));
    for (int i = 0; i < N; i++) mem_resp(ids[i], 64'hBAD);
    drain("R8");

    cur_req = "R9";
    order_test(41, 40, 26'h3000, "R9");
    order_test(1, 63, 26'h3100, "R9");

    report();
  end
endmodule